// File: doc/BRIEF.md
# Pipelined Bus Data-Tenure Scheduler

This block sits on the master side of a split-transaction bus. Each read or write whose address phase has been acknowledged leaves a pending data tenure. The block keeps those tenures in one queue, in the order their address phases finished. When the system grants the data bus, the block picks the tenure to run, raises data-bus-busy and steps through a fixed-length burst of data beats.

Normally the head of the queue always runs next, so data follows addresses strictly in order. The system can also raise a write-first hint on the same clock as a usable grant. If any write is pending at that moment, the oldest write runs instead of the head. A write can therefore overtake earlier reads, and the write ends up inside a read: read address, write address, write data, read data. Writes never pass other writes. When an entry is taken from the middle of the queue, the entries behind it move up, so the remaining order is kept.

Top module: `dtenure_sched`

## Requirements
- R1: After reset, bus_busy, ten_start and beat_valid are low and req_ready is high.
- R2: With the write-first hint low at the grant, the tenure issued is the oldest pending entry. ten_is_wr (1 = write, 0 = read) and ten_tag show that entry's kind and tag from the cycle after the grant.
- R3: A grant counts only when data_grant is high, bus_busy is low and at least one tenure is pending. It raises bus_busy and a one-cycle ten_start in the next cycle. A grant during a burst or with an empty queue changes nothing.
- R4: wr_first has no effect unless it is high on the same edge as a grant that counts. This holds when it arrives during a burst and when it arrives with no grant.
- R5: A grant that counts, with wr_first high and at least one write pending, issues the oldest pending write, even when reads are older.
- R6: A grant that counts, with wr_first high and no write pending, issues the oldest pending entry.
- R7: Writes are issued in the order they were enqueued. After an entry is removed from the middle of the queue, the entries that remain keep their relative order.
- R8: The queue holds 4 tenures. A tenure is enqueued on a clock edge where addr_ack, req_valid and req_ready are all high. req_ready is low exactly when 4 tenures are pending. An acknowledge while req_ready is low enqueues nothing.
- R9: A burst is 4 beats. beat_valid equals bus_busy, and a beat completes on an edge where beat_ack is high. beat_last is high during the 4th beat. bus_busy falls on the edge that completes the 4th beat, and the burst stalls while beat_ack is low.
- R10: A read enqueued before a write, followed by a grant with wr_first high, produces the write burst first and then the read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction offered for address acknowledge |
| req_is_wr | input | 1 | Kind of offered transaction: 1 write, 0 read |
| req_tag | input | 4 | Address tag of offered transaction |
| req_ready | output | 1 | Queue has room; low when 4 tenures are pending |
| addr_ack | input | 1 | Address phase acknowledged by the system |
| data_grant | input | 1 | Data bus grant |
| wr_first | input | 1 | Write-first hint, sampled with the grant |
| bus_busy | output | 1 | Data bus held for the running tenure |
| ten_start | output | 1 | One-cycle pulse on the first cycle of a tenure |
| ten_is_wr | output | 1 | Kind of the running tenure |
| ten_tag | output | 4 | Tag of the running tenure |
| beat_valid | output | 1 | Data beat offered |
| beat_ack | input | 1 | Data beat accepted |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
Corrupted queue state, such as a lost, duplicated or misordered entry, shows up at ten_tag and ten_is_wr on the very next tenure that reaches it. It can also show as req_ready flipping one enqueue early or late. A bad burst counter shows within four beats, as a misplaced beat_last or as bus_busy falling at the wrong edge. A grant or hint that should have been ignored but was not shows as ten_start firing again or as the wrong entry being issued. The bench therefore compares every issued tenure against a model queue, and checks ready, busy and beat framing on every cycle it drives.

// File: rtl/dts_pkg.sv
package dts_pkg;
  // kind of a pending data tenure
  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } kind_e;
endpackage

// File: rtl/dts_queue.sv
module dts_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         push_wr,
  input  logic [TAG_W-1:0]             push_tag,
  input  logic                         pop,
  input  logic [IDX_W-1:0]             pop_idx,
  output logic [DEPTH-1:0]             q_wr,
  output logic [DEPTH-1:0][TAG_W-1:0]  q_tag,
  output logic [CNT_W-1:0]             count,
  output logic                         full,
  output logic                         empty
);

  logic [DEPTH-1:0]            wr_q, wr_n;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n, cnt_mid;
  logic                        en;

  assign en = push | pop;

  // compact on removal, then append behind the survivors
  always_comb begin
    wr_n  = wr_q;
    tag_n = tag_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) begin
          wr_n[i]  = wr_q[i+1];
          tag_n[i] = tag_q[i+1];
        end
      end
    end
    cnt_mid = cnt_q - CNT_W'(pop);
    if (push) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (CNT_W'(j) == cnt_mid) begin
          wr_n[j]  = push_wr;
          tag_n[j] = push_tag;
        end
      end
    end
    cnt_n = cnt_mid + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      tag_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      wr_q  <= wr_n;
      tag_q <= tag_n;
      cnt_q <= cnt_n;
    end
  end

  assign q_wr  = wr_q;
  assign q_tag = tag_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH) || pop)); // R8
  AST_POP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0 && CNT_W'(pop_idx) < cnt_q)); // R3
  AST_PASS_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pop_idx != '0) |-> (wr_q[pop_idx] && !wr_q[0])); // R7

endmodule

// File: rtl/dts_pick.sv
module dts_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] q_wr,
  input  logic [CNT_W-1:0] count,
  input  logic             hint,
  output logic [IDX_W-1:0] sel_idx,
  output logic             any_wr
);
  import dts_pkg::*;

  logic [IDX_W-1:0] first_wr;
  logic             found;

  // oldest live write entry
  always_comb begin
    found    = 1'b0;
    first_wr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && CNT_W'(i) < count && kind_e'(q_wr[i]) == KIND_WRITE) begin
        found    = 1'b1;
        first_wr = IDX_W'(i);
      end
    end
  end

  assign any_wr  = found;
  assign sel_idx = (hint && found) ? first_wr : '0;

endmodule

// File: rtl/dts_burst.sv
module dts_burst #(
  parameter int BEATS = 4,
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic beat_ack,
  output logic busy,
  output logic last
);

  logic          busy_q, busy_n;
  logic [BW-1:0] cnt_q, cnt_n;
  logic          at_end;

  assign at_end = (cnt_q == BW'(BEATS - 1));

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q && beat_ack) begin
      if (at_end) begin
        busy_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && at_end;

  AST_FALL_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(beat_ack)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start); // R3

endmodule

// File: rtl/dtenure_sched.sv
module dtenure_sched #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_wr,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  input  logic             addr_ack,
  input  logic             data_grant,
  input  logic             wr_first,
  output logic             bus_busy,
  output logic             ten_start,
  output logic             ten_is_wr,
  output logic [TAG_W-1:0] ten_tag,
  output logic             beat_valid,
  input  logic             beat_ack,
  output logic             beat_last
);

  logic [DEPTH-1:0]            q_wr;
  logic [DEPTH-1:0][TAG_W-1:0] q_tag;
  logic [CNT_W-1:0]            count;
  logic                        full, empty;
  logic [IDX_W-1:0]            sel_idx;
  logic                        any_wr;
  logic                        busy, last;
  logic                        push, start;

  logic             start_q;
  logic             wr_q, wr_n;
  logic [TAG_W-1:0] tag_q, tag_n;

  assign push  = addr_ack && req_valid && !full;
  assign start = data_grant && !busy && !empty;

  dts_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_wr  (req_is_wr),
    .push_tag (req_tag),
    .pop      (start),
    .pop_idx  (sel_idx),
    .q_wr     (q_wr),
    .q_tag    (q_tag),
    .count    (count),
    .full     (full),
    .empty    (empty)
  );

  dts_pick #(.DEPTH(DEPTH)) i_pick (
    .q_wr    (q_wr),
    .count   (count),
    .hint    (wr_first),
    .sel_idx (sel_idx),
    .any_wr  (any_wr)
  );

  dts_burst #(.BEATS(BEATS)) i_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .beat_ack (beat_ack),
    .busy     (busy),
    .last     (last)
  );

  always_comb begin
    wr_n  = q_wr[sel_idx];
    tag_n = q_tag[sel_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      wr_q    <= 1'b0;
      tag_q   <= '0;
    end else begin
      start_q <= start;
      if (start) begin
        wr_q  <= wr_n;
        tag_q <= tag_n;
      end
    end
  end

  assign req_ready  = !full;
  assign bus_busy   = busy;
  assign beat_valid = busy;
  assign beat_last  = last;
  assign ten_start  = start_q;
  assign ten_is_wr  = wr_q;
  assign ten_tag    = tag_q;

  AST_RISE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(data_grant)); // R3
  AST_START_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ten_start |-> bus_busy); // R3
  AST_PROMOTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wr_first && any_wr) |=> ten_is_wr); // R5

endmodule

// File: tb/test_dtenure_sched.sv
module test_dtenure_sched;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_is_wr = 1'b0, addr_ack = 1'b0;
  logic [3:0] req_tag = '0;
  logic       data_grant = 1'b0, wr_first = 1'b0, beat_ack = 1'b0;
  logic       req_ready, bus_busy, ten_start, ten_is_wr, beat_valid, beat_last;
  logic [3:0] ten_tag;

  int checks = 0, errs = 0;
  bit done = 0;

  // reference queue
  int m_n = 0;
  bit m_wr[4];
  int m_tag[4];
  int tag_ctr = 0;

  always #(CLK_P/2) clk = ~clk;

  dtenure_sched i_dtenure_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_wr(req_is_wr),
    .req_tag(req_tag), .req_ready(req_ready), .addr_ack(addr_ack),
    .data_grant(data_grant), .wr_first(wr_first), .bus_busy(bus_busy),
    .ten_start(ten_start), .ten_is_wr(ten_is_wr), .ten_tag(ten_tag),
    .beat_valid(beat_valid), .beat_ack(beat_ack), .beat_last(beat_last)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_pick(bit hint);
    if (hint) for (int i = 0; i < m_n; i++) if (m_wr[i]) return i;
    return 0;
  endfunction

  function automatic bit ref_any_wr();
    for (int i = 0; i < m_n; i++) if (m_wr[i]) return 1;
    return 0;
  endfunction

  task automatic ref_pop(int k);
    for (int i = k; i < 3; i++) begin m_wr[i] = m_wr[i+1]; m_tag[i] = m_tag[i+1]; end
    m_n--;
  endtask

  task automatic ref_push(bit w, int t);
    m_wr[m_n] = w; m_tag[m_n] = t; m_n++;
  endtask

  // present one acknowledged address phase
  task automatic enq(bit w);
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = (m_n < 4);
    chk(req_ready == exp_rdy, "R8 ready", req_ready, exp_rdy);
    req_valid = 1; addr_ack = 1; req_is_wr = w; req_tag = 4'(tag_ctr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; addr_ack = 0;
    if (exp_rdy) ref_push(w, tag_ctr);
    tag_ctr = (tag_ctr + 1) % 16;
  endtask

  task automatic run_burst();
    int n = 0;
    bit first = 1;
    while (n < 4) begin
      bit a;
      chk(beat_valid == 1, "R9 beat_valid", beat_valid, 1);
      chk(beat_last == (n == 3), "R9 beat_last", beat_last, int'(n == 3));
      chk(ten_start == first, "R3 start pulse", ten_start, int'(first));
      first = 0;
      a = ($urandom % 3) != 0;
      beat_ack = a;
      data_grant = $urandom % 2;   // ignored while busy (R3)
      wr_first = $urandom % 2;     // ignored while busy (R4)
      @(posedge clk);
      if (a) n++;
      @(negedge clk);
    end
    beat_ack = 0; data_grant = 0; wr_first = 0;
    chk(bus_busy == 0, "R9 busy release", bus_busy, 0);
  endtask

  // grant that counts, optional same-cycle enqueue
  task automatic grant(bit hint, bit also_push, string req);
    int k, e_tag;
    bit e_wr, pushed, pw;
    @(negedge clk);
    data_grant = 1; wr_first = hint;
    pushed = 0;
    pw = $urandom % 2;
    if (also_push && m_n < 4) begin
      req_valid = 1; addr_ack = 1; req_is_wr = pw; req_tag = 4'(tag_ctr); pushed = 1;
    end
    k = ref_pick(hint);
    e_wr = m_wr[k]; e_tag = m_tag[k];
    @(posedge clk);
    @(negedge clk);
    data_grant = 0; wr_first = 0; req_valid = 0; addr_ack = 0;
    ref_pop(k);
    if (pushed) begin ref_push(pw, tag_ctr); tag_ctr = (tag_ctr + 1) % 16; end
    chk(bus_busy == 1, "R3 busy rise", bus_busy, 1);
    chk(ten_is_wr == e_wr, req, ten_is_wr, e_wr);
    chk(ten_tag == 4'(e_tag), req, ten_tag, e_tag);
    run_burst();
  endtask

  task automatic grant_auto(bit hint, bit also_push);
    if (!hint) grant(hint, also_push, "R2 order");
    else if (ref_any_wr()) grant(hint, also_push, "R5 R7 promote");
    else grant(hint, also_push, "R6 no write");
  endtask

  task automatic idle_grant();
    @(negedge clk);
    data_grant = 1; wr_first = $urandom % 2;
    @(posedge clk);
    @(negedge clk);
    data_grant = 0; wr_first = 0;
    chk(bus_busy == 0, "R3 empty grant", bus_busy, 0);
    chk(ten_start == 0, "R3 empty grant start", ten_start, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(bus_busy == 0, "R1 busy", bus_busy, 0);
    chk(ten_start == 0, "R1 start", ten_start, 0);
    chk(beat_valid == 0, "R1 beat_valid", beat_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready", req_ready, 1);

    idle_grant();                                     // R3 empty queue

    enq(0); enq(1); grant_auto(0, 0); grant_auto(0, 0); // R2 in order

    enq(0); enq(1); grant_auto(1, 0); grant_auto(0, 0); // R10 envelope: write then read

    enq(0); enq(0); grant_auto(1, 0); grant_auto(1, 0); // R6

    // R4: hint without grant, hint during burst
    enq(0); enq(0); enq(1);
    grant_auto(0, 0);
    @(negedge clk); wr_first = 1; @(negedge clk); wr_first = 0;
    grant_auto(0, 0); grant_auto(0, 0);

    // R7 compaction: R W R W, promote first write
    enq(0); enq(1); enq(0); enq(1);
    grant_auto(1, 0); grant_auto(0, 0); grant_auto(0, 0); grant_auto(0, 0);

    // R8 full queue, extra acknowledge dropped
    enq(1); enq(0); enq(1); enq(0); enq(1);
    @(negedge clk);
    chk(req_ready == 0, "R8 full", req_ready, 0);
    while (m_n > 0) grant_auto($urandom % 2, 0);
    idle_grant();

    for (int it = 0; it < 300; it++) begin
      int r = $urandom % 4;
      if (r < 2 && m_n <= 4) enq($urandom % 2);
      else if (m_n > 0) grant_auto($urandom % 2, $urandom % 2);
      else idle_grant();
    end
    while (m_n > 0) grant_auto($urandom % 2, 0);
    idle_grant();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule